// File: doc/BRIEF.md
# Disk Transfer FIFO with DMA Request Pacing

This block is a 16-entry byte queue placed between the byte engine of a disk controller and a host DMA channel. One programmable threshold controls when the DMA request goes up and when it comes down. The hysteresis runs one way when the disk fills the queue for the host, and the other way when the host fills it for the disk. The request can also be raised early when the last byte of a sector arrives.

A command is started with a direction. It then ends in one of three ways:

- normally, through a host terminal-count strobe;
- abnormally, through an overrun, an underrun or an end-of-track pulse from the disk engine;
- naturally, once all 512 bytes of the sector have crossed the disk side.

After an early end, the disk side still runs to the end of the sector. In the host-to-disk direction it drains the queue and then receives zero bytes. In the disk-to-host direction its bytes are thrown away. The block returns to idle only at the sector boundary.

The 4-bit threshold field holds the threshold minus one, so a field of f means a threshold of f+1 bytes.

Top module: `fdc_dma_pacer`

## Requirements
- R1: Bytes leave the queue in the order they entered, the queue never holds more than 16 bytes, and a push and a pop accepted in the same cycle leave the occupancy unchanged.
- R2: The threshold field is written with `thr_we` only while idle; a write during a command has no effect. Field f means a threshold of f+1.
- R3: Disk-to-host: on the clock edge where the occupancy becomes at least max(16-(f+1), 1), the request goes high.
- R4: Disk-to-host: the disk push that is the 512th byte of the sector raises the request on its own edge, even when the occupancy is below the level of R3.
- R5: Disk-to-host: the request stays high until the occupancy reaches 0, and drops on that same edge.
- R6: Host-to-disk: a start is honoured only while idle. The request is high on the edge that accepts the start, and stays high until the edge where the occupancy becomes 16, where it drops.
- R7: Host-to-disk: once the request has dropped on full, it rises again on the edge where the occupancy becomes at most f+1.
- R8: A host acknowledge with `dma_tc` high during a command sets `term_ok`. The request is low from the next edge until the command ends, and later host acknowledges are ignored.
- R9: The following end the command abnormally: a push while full that is not paired with a pop (sets `flag_ovr`), a pop while empty (sets `flag_unr`), or `dsk_eot`. In each case `term_abn` is set and the request drops. `term_ok` and `term_abn` are never both high.
- R10: Host-to-disk: every disk pop during a command, whether it succeeds or not, advances the sector count. After an early end, disk pops first drain the queued bytes and then read 0x00. `xfer_busy` falls on the edge of the 512th disk byte, and `dsk_rdata` reads 0x00 whenever the queue is empty.
- R11: Disk-to-host: an early end flushes the queue. Every disk push during a command still advances the sector count. After the early end, disk pushes are discarded, no flag is set, and `xfer_busy` falls on the 512th push.
- R12: Natural completion with `term_ok` happens in two ways. Host-to-disk, it happens on the 512th disk pop, and the request stays high until then even after the host has sent its last byte. Disk-to-host, it happens on the edge where the sector is complete and the queue becomes empty.
- R13: A synchronous reset gives an empty queue, a low request, cleared status, idle state and a threshold field of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thr_we | input | 1 | Threshold field write strobe |
| thr_wdata | input | 4 | Threshold minus one |
| cmd_start | input | 1 | Start of a transfer command's execution |
| cmd_h2d | input | 1 | Direction at start: 1 host-to-disk, 0 disk-to-host |
| dma_req | output | 1 | DMA service request to the host |
| dma_ack | input | 1 | One host byte transfer in this cycle |
| dma_tc | input | 1 | Terminal count, qualified by dma_ack |
| dma_wdata | input | 8 | Byte written by the host |
| dma_rdata | output | 8 | Byte at the queue head for the host |
| dsk_push | input | 1 | Disk engine pushes a byte |
| dsk_wdata | input | 8 | Byte pushed by the disk engine |
| dsk_pop | input | 1 | Disk engine takes a byte |
| dsk_rdata | output | 8 | Byte for the disk engine, 0x00 when empty |
| dsk_eot | input | 1 | End-of-track pulse from the disk engine |
| dsk_sect_end | output | 1 | Pulse with the 512th disk-side byte |
| xfer_busy | output | 1 | A command is active or finishing its sector |
| term_ok | output | 1 | Normal termination, held until next start |
| term_abn | output | 1 | Abnormal termination, held until next start |
| flag_ovr | output | 1 | Overrun caused the termination |
| flag_unr | output | 1 | Underrun caused the termination |

## Verification
A fault in the occupancy count shows at once at the request pin. The request rises or falls one byte early or late compared with the occupancy the bench computes from the strobes it drove, and this is visible on the edge after the faulty byte.

A fault in the sector position appears later. It shows as `xfer_busy` falling on the wrong disk byte, or as a missing early request at the end of the sector, up to 512 disk strobes after the fault.

A fault in the read pointer shows as a wrong byte at the next pop. A padding fault shows as a nonzero byte read from an empty queue.

// File: rtl/fdc_pace_pkg.sv
package fdc_pace_pkg;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_RUN  = 2'd1,
    XS_FIN  = 2'd2
  } xfer_st_e;

  // programmed field holds threshold-1
  function automatic int unsigned thr_bytes(input int unsigned field);
    return field + 1;
  endfunction

  // disk-to-host: raise once occupancy >= depth - threshold (never at zero)
  function automatic logic drain_hit(input int unsigned occ,
                                     input int unsigned field,
                                     input int unsigned depth);
    return (occ != 0) && ((occ + thr_bytes(field)) >= depth);
  endfunction

  // host-to-disk: raise again once occupancy has fallen to the threshold
  function automatic logic fill_hit(input int unsigned occ,
                                    input int unsigned field);
    return occ <= thr_bytes(field);
  endfunction

endpackage

// File: rtl/fdc_pace_fifo.sv
module fdc_pace_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] occ_mv
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  // occupancy after this cycle's moves, before any flush
  assign occ_mv = occ + CW'(push) - CW'(pop);
  assign head   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !flush && !rst) begin
      mem[wr_ptr] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      occ <= occ_mv;
    end
  end

endmodule

// File: rtl/fdc_pace_sect.sv
module fdc_pace_sect #(
  parameter int SECT = 512,
  localparam int SW  = $clog2(SECT)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic last,
  output logic full
);

  logic [SW-1:0] pos;

  assign last = step && (pos == SW'(SECT - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pos  <= '0;
      full <= 1'b0;
    end else if (step) begin
      pos <= last ? '0 : pos + SW'(1);
      if (last) full <= 1'b1;
    end
  end

endmodule

// File: rtl/fdc_pace_req.sv
module fdc_pace_req import fdc_pace_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int TW   = $clog2(DEPTH),
  localparam int CW   = TW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stay_run,
  input  logic          start,
  input  logic          start_h2d,
  input  logic          h2d,
  input  logic [CW-1:0] occ_mv,
  input  logic [TW-1:0] thr,
  input  logic          sect_last,
  output logic          req
);

  logic req_d;
  logic at_full;
  logic at_empty;

  assign at_full  = occ_mv == CW'(DEPTH);
  assign at_empty = occ_mv == '0;

  always_comb begin
    req_d = req;
    if (!stay_run) begin
      req_d = 1'b0;
    end else if (start) begin
      req_d = start_h2d;
    end else if (h2d) begin
      if (at_full)                           req_d = 1'b0;
      else if (fill_hit(32'(occ_mv), 32'(thr))) req_d = 1'b1;
    end else begin
      if (at_empty) req_d = 1'b0;
      else if (sect_last || drain_hit(32'(occ_mv), 32'(thr), DEPTH)) req_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= req_d;
  end

endmodule

// File: rtl/fdc_dma_pacer.sv
module fdc_dma_pacer import fdc_pace_pkg::*; #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int SECT  = 512,
  localparam int TW   = $clog2(DEPTH),
  localparam int CW   = TW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          thr_we,
  input  logic [TW-1:0] thr_wdata,
  input  logic          cmd_start,
  input  logic          cmd_h2d,
  output logic          dma_req,
  input  logic          dma_ack,
  input  logic          dma_tc,
  input  logic [W-1:0]  dma_wdata,
  output logic [W-1:0]  dma_rdata,
  input  logic          dsk_push,
  input  logic [W-1:0]  dsk_wdata,
  input  logic          dsk_pop,
  output logic [W-1:0]  dsk_rdata,
  input  logic          dsk_eot,
  output logic          dsk_sect_end,
  output logic          xfer_busy,
  output logic          term_ok,
  output logic          term_abn,
  output logic          flag_ovr,
  output logic          flag_unr
);

  xfer_st_e      st_q, st_nx;
  logic          dir_q;
  logic [TW-1:0] thr_q;
  logic [CW-1:0] occ, occ_mv;
  logic [W-1:0]  head;

  // named internal events, also used by the bound checker
  logic run, fin, start_evt;
  logic push_rq, pop_rq, push_ok, pop_ok, full, empty;
  logic ovr_evt, unr_evt, tc_evt, abn_evt, cmpl_evt;
  logic sect_step, sect_last, sect_full, sect_done_now;
  logic flush, stay_run;

  assign run       = st_q == XS_RUN;
  assign fin       = st_q == XS_FIN;
  assign start_evt = cmd_start && (st_q == XS_IDLE);

  assign full  = occ == CW'(DEPTH);
  assign empty = occ == '0;

  assign push_rq = run && (dir_q ? dma_ack : dsk_push);
  assign pop_rq  = dir_q ? ((run || fin) && dsk_pop) : (run && dma_ack);
  assign pop_ok  = pop_rq && !empty;
  assign push_ok = push_rq && (!full || pop_ok);

  assign ovr_evt  = push_rq && !push_ok;
  assign unr_evt  = run && pop_rq && !pop_ok;
  assign tc_evt   = run && dma_ack && dma_tc;
  assign abn_evt  = run && (ovr_evt || unr_evt || dsk_eot);

  assign sect_step     = (run || fin) && (dir_q ? dsk_pop : dsk_push);
  assign sect_done_now = sect_full || sect_last;
  assign cmpl_evt      = run && !abn_evt && !tc_evt &&
                         (dir_q ? sect_last : (sect_done_now && occ_mv == '0));

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      XS_IDLE: if (start_evt) st_nx = XS_RUN;
      XS_RUN: begin
        if (abn_evt || tc_evt) st_nx = sect_done_now ? XS_IDLE : XS_FIN;
        else if (cmpl_evt)     st_nx = XS_IDLE;
      end
      XS_FIN:  if (sect_last) st_nx = XS_IDLE;
      default: st_nx = XS_IDLE;
    endcase
  end

  assign stay_run = st_nx == XS_RUN;
  assign flush    = start_evt ||
                    ((st_q != XS_IDLE) && (st_nx == XS_IDLE)) ||
                    (run && (st_nx == XS_FIN) && !dir_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= XS_IDLE;
      dir_q <= 1'b0;
      thr_q <= '0;
    end else begin
      st_q <= st_nx;
      if (start_evt) dir_q <= cmd_h2d;
      if (thr_we && st_q == XS_IDLE) thr_q <= thr_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start_evt) begin
      term_ok  <= 1'b0;
      term_abn <= 1'b0;
      flag_ovr <= 1'b0;
      flag_unr <= 1'b0;
    end else if (abn_evt) begin
      term_abn <= 1'b1;
      if (ovr_evt) flag_ovr <= 1'b1;
      if (unr_evt) flag_unr <= 1'b1;
    end else if (tc_evt || cmpl_evt) begin
      term_ok <= 1'b1;
    end
  end

  fdc_pace_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .push   (push_ok),
    .pop    (pop_ok),
    .din    (dir_q ? dma_wdata : dsk_wdata),
    .head   (head),
    .occ    (occ),
    .occ_mv (occ_mv)
  );

  fdc_pace_sect #(.SECT(SECT)) u_sect (
    .clk   (clk),
    .rst   (rst),
    .clear (start_evt),
    .step  (sect_step),
    .last  (sect_last),
    .full  (sect_full)
  );

  fdc_pace_req #(.DEPTH(DEPTH)) u_req (
    .clk       (clk),
    .rst       (rst),
    .stay_run  (stay_run),
    .start     (start_evt),
    .start_h2d (cmd_h2d),
    .h2d       (dir_q),
    .occ_mv    (occ_mv),
    .thr       (thr_q),
    .sect_last (sect_last),
    .req       (dma_req)
  );

  assign dma_rdata    = head;
  assign dsk_rdata    = empty ? '0 : head;
  assign dsk_sect_end = sect_last;
  assign xfer_busy    = st_q != XS_IDLE;

endmodule

// File: rtl/fdc_pace_chk.sv
module fdc_pace_chk import fdc_pace_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int TW   = $clog2(DEPTH),
  localparam int CW   = TW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    st,
  input logic          dir_q,
  input logic [CW-1:0] occ,
  input logic [TW-1:0] thr_q,
  input logic          req,
  input logic          term_ok,
  input logic          term_abn,
  input logic          tc_evt,
  input logic          abn_evt,
  input logic          start_evt,
  input logic          cmd_h2d
);

  logic in_run;
  assign in_run = st == XS_RUN;

  p_cap_r1: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= DEPTH);

  p_d2h_level_r3: assert property (@(posedge clk) disable iff (rst)
    (in_run && !dir_q && occ != '0 && (int'(occ) + int'(thr_q) + 1 >= DEPTH)) |-> req);

  p_d2h_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (!dir_q && occ == '0) |-> !req);

  p_h2d_start_r6: assert property (@(posedge clk) disable iff (rst)
    (start_evt && cmd_h2d) |=> req);

  p_h2d_full_r6: assert property (@(posedge clk) disable iff (rst)
    (in_run && dir_q && int'(occ) == DEPTH) |-> !req);

  p_h2d_level_r7: assert property (@(posedge clk) disable iff (rst)
    (in_run && dir_q && int'(occ) != DEPTH && int'(occ) <= int'(thr_q) + 1) |-> req);

  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !in_run |-> !req);

  p_tc_r8: assert property (@(posedge clk) disable iff (rst)
    (tc_evt && !abn_evt) |=> (term_ok && !req));

  p_abn_r9: assert property (@(posedge clk) disable iff (rst)
    abn_evt |=> (term_abn && !req));

  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(term_ok && term_abn));

endmodule

bind fdc_dma_pacer fdc_pace_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .st        (st_q),
  .dir_q     (dir_q),
  .occ       (occ),
  .thr_q     (thr_q),
  .req       (dma_req),
  .term_ok   (term_ok),
  .term_abn  (term_abn),
  .tc_evt    (tc_evt),
  .abn_evt   (abn_evt),
  .start_evt (start_evt),
  .cmd_h2d   (cmd_h2d)
);

// File: tb/sim_fdc_dma_pacer.sv
module sim_fdc_dma_pacer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       thr_we = 0, cmd_start = 0, cmd_h2d = 0;
  logic [3:0] thr_wdata = '0;
  logic       dma_ack = 0, dma_tc = 0, dsk_push = 0, dsk_pop = 0, dsk_eot = 0;
  logic [7:0] dma_wdata = '0, dsk_wdata = '0;
  logic       dma_req, dsk_sect_end, xfer_busy, term_ok, term_abn, flag_ovr, flag_unr;
  logic [7:0] dma_rdata, dsk_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fdc_dma_pacer u0 (
    .clk(clk), .rst(rst), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .cmd_start(cmd_start), .cmd_h2d(cmd_h2d), .dma_req(dma_req),
    .dma_ack(dma_ack), .dma_tc(dma_tc), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata),
    .dsk_push(dsk_push), .dsk_wdata(dsk_wdata), .dsk_pop(dsk_pop), .dsk_rdata(dsk_rdata),
    .dsk_eot(dsk_eot), .dsk_sect_end(dsk_sect_end), .xfer_busy(xfer_busy),
    .term_ok(term_ok), .term_abn(term_abn), .flag_ovr(flag_ovr), .flag_unr(flag_unr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // one clock: inputs set before the call are applied at the edge, then cleared
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    thr_we = 0; cmd_start = 0; dma_ack = 0; dma_tc = 0;
    dsk_push = 0; dsk_pop = 0; dsk_eot = 0;
  endtask

  task automatic set_thr(input int f);
    thr_we = 1; thr_wdata = 4'(f); tick();
  endtask

  task automatic start(input logic h2d);
    cmd_start = 1; cmd_h2d = h2d; tick();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=%0d expected=0 cycles left", WATCHDOG);
    summary();
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R13 reset state
    chk("R13 req", dma_req, 0);
    chk("R13 busy", xfer_busy, 0);
    chk("R13 term_ok", term_ok, 0);
    chk("R13 term_abn", term_abn, 0);
    chk("R13 ovr", flag_ovr, 0);
    chk("R13 unr", flag_unr, 0);

    // R2 default field 0 -> level 15; a write while busy is ignored; then R9 overrun
    start(0);
    set_thr(15);
    for (int k = 1; k <= 16; k++) begin
      dsk_push = 1; dsk_wdata = 8'(k); tick();
      chk("R2 default threshold req", dma_req, int'(k >= 15));
    end
    dsk_push = 1; tick();
    chk("R9 overrun flag", flag_ovr, 1);
    chk("R9 overrun term_abn", term_abn, 1);
    chk("R9 overrun req", dma_req, 0);
    chk("R9 overrun busy", xfer_busy, 1);
    for (int j = 1; j <= 495; j++) begin
      dsk_push = 1; tick();
      chk("R11 discard busy", xfer_busy, int'(j < 495));
    end

    // disk-to-host sweep over every threshold field
    for (int t = 0; t < 16; t++) begin
      int lvl;
      lvl = (15 - t < 1) ? 1 : 15 - t;
      set_thr(t);
      start(0);
      chk("R5 req after start", dma_req, 0);
      for (int k = 1; k <= 16; k++) begin
        dsk_push = 1; dsk_wdata = 8'(t * 16 + k); tick();
        chk("R3 drain level", dma_req, int'(k >= lvl));
      end
      for (int k = 1; k <= 16; k++) begin
        chk("R1 host order", dma_rdata, (t * 16 + k) % 256);
        dma_ack = 1; dma_tc = (k == 16); tick();
        chk("R5 held to empty", dma_req, int'(k < 16));
      end
      chk("R8 tc term_ok", term_ok, 1);
      for (int j = 1; j <= 496; j++) begin
        dsk_push = 1; dsk_wdata = 8'hAA; tick();
        chk("R11 req quiet", dma_req, 0);
        chk("R11 busy", xfer_busy, int'(j < 496));
      end
      chk("R11 no ovr", flag_ovr, 0);
    end

    // host-to-disk sweep over every threshold field, ended by end-of-track
    for (int t = 0; t < 16; t++) begin
      set_thr(t);
      start(1);
      chk("R6 req at start", dma_req, 1);
      for (int k = 1; k <= 16; k++) begin
        dma_ack = 1; dma_wdata = 8'(t * 16 + k + 3); tick();
        chk("R6 drop at full", dma_req, int'(k < 16));
      end
      for (int j = 1; j <= 16; j++) begin
        chk("R1 disk order", dsk_rdata, (t * 16 + j + 3) % 256);
        dsk_pop = 1; tick();
        chk("R7 refill level", dma_req, int'((16 - j) <= t + 1));
      end
      dsk_eot = 1; tick();
      chk("R9 eot term_abn", term_abn, 1);
      chk("R9 eot req", dma_req, 0);
      for (int j = 1; j <= 496; j++) begin
        chk("R10 pad zero", dsk_rdata, 0);
        dsk_pop = 1; tick();
        chk("R10 busy", xfer_busy, int'(j < 496));
      end
    end

    // R9 underrun host-to-disk
    start(1);
    for (int k = 1; k <= 2; k++) begin
      dma_ack = 1; dma_wdata = 8'(k + 50); tick();
    end
    for (int k = 1; k <= 2; k++) begin
      chk("R1 underrun data", dsk_rdata, k + 50);
      dsk_pop = 1; tick();
    end
    chk("R10 empty reads zero", dsk_rdata, 0);
    dsk_pop = 1; tick();
    chk("R9 underrun flag", flag_unr, 1);
    chk("R9 underrun term_abn", term_abn, 1);
    chk("R9 underrun term_ok", term_ok, 0);
    chk("R9 underrun req", dma_req, 0);
    for (int j = 1; j <= 509; j++) begin
      dsk_pop = 1; tick();
      chk("R10 underrun busy", xfer_busy, int'(j < 509));
    end

    // R8 host-to-disk terminal count, later acks ignored, R10 drain then pad
    start(1);
    for (int k = 1; k <= 3; k++) begin
      dma_ack = 1; dma_tc = (k == 3); dma_wdata = 8'(k + 100); tick();
    end
    chk("R8 tc term_ok", term_ok, 1);
    chk("R8 tc req", dma_req, 0);
    dma_ack = 1; dma_wdata = 8'h77; tick();
    chk("R8 req stays low", dma_req, 0);
    for (int j = 1; j <= 512 - 0; j++) begin
      if (j > 509) break;
      if (j <= 3) chk("R8 ack ignored, queued data", dsk_rdata, j + 100);
      else        chk("R10 pad after tc", dsk_rdata, 0);
      dsk_pop = 1; tick();
    end
    for (int j = 510; j <= 512; j++) begin
      chk("R10 pad tail", dsk_rdata, 0);
      dsk_pop = 1; tick();
      chk("R10 busy at tail", xfer_busy, int'(j < 512));
    end

    // R4 early trigger on sector end, R12 disk-to-host natural completion
    set_thr(0);
    start(0);
    dsk_push = 1; dsk_wdata = 8'(0); tick();
    for (int i = 1; i <= 510; i++) begin
      chk("R1 pass-through order", dma_rdata, (i - 1) % 256);
      dsk_push = 1; dsk_wdata = 8'(i); dma_ack = 1; tick();
      chk("R4 below level", dma_req, 0);
    end
    dsk_push = 1; dsk_wdata = 8'(511); tick();
    chk("R4 sector end raises req", dma_req, 1);
    chk("R4 busy", xfer_busy, 1);
    chk("R1 head", dma_rdata, 510 % 256);
    dma_ack = 1; tick();
    chk("R5 held", dma_req, 1);
    chk("R1 last byte", dma_rdata, 511 % 256);
    dma_ack = 1; tick();
    chk("R5 drop at empty", dma_req, 0);
    chk("R12 d2h busy", xfer_busy, 0);
    chk("R12 d2h term_ok", term_ok, 1);

    // R12 host-to-disk natural completion
    start(1);
    dma_ack = 1; dma_wdata = 8'(0); tick();
    for (int i = 1; i <= 511; i++) begin
      chk("R1 stream order", dsk_rdata, (i - 1) % 256);
      dma_ack = 1; dma_wdata = 8'(i); dsk_pop = 1; tick();
    end
    chk("R12 req held after last host byte", dma_req, 1);
    chk("R12 busy before last pop", xfer_busy, 1);
    chk("R1 final byte", dsk_rdata, 511 % 256);
    dsk_pop = 1; tick();
    chk("R12 h2d busy", xfer_busy, 0);
    chk("R12 h2d term_ok", term_ok, 1);
    chk("R12 h2d req", dma_req, 0);

    summary();
    $finish;
  end

endmodule